// File: doc/BRIEF.md
# ADC Noise Folding Accumulator

This block turns raw digitized noise from two converter channels into 32-bit entropy words. Every time both channels deliver a 12-bit sample, the two samples are XORed together and everything but the five least significant bits is thrown away. The upper bits of a noise waveform mostly carry its DC offset and slow amplitude drift. Keeping only the low bits wraps those variations into the random value instead of passing them on as bias.

Each 5-bit value is folded into a 32-bit accumulator: the accumulator moves up by five bit positions and the new value is XORed into its bottom. After a software-set number of folds, the accumulator is handed to the output as a finished word with a valid flag, and accumulation starts again from zero. The nominal setting is 32 folds, which turns samples arriving at about 1 MSPS into words at about 31.25 kHz. A consumer takes a word by pulsing an acknowledge. If a new word finishes before the old one was taken, the new word replaces it and a sticky overrun flag is raised.

Top module: `noise_fold_acc`

## Requirements
- R1: After reset, word_valid is 0, overrun is 0 and word_out is 0.
- R2: The folded value of a sample pair is bits [4:0] of samp_a XOR samp_b; bits [11:5] of either sample have no effect on any output.
- R3: Each accepted sample pair updates the accumulator as acc = ((acc << 5) truncated to 32 bits) XOR {27'b0, value}. Bits shifted past bit 31 are lost. Every word starts from an accumulator of zero.
- R4: With fold_count = N (N >= 1), a word completes on the N-th accepted sample pair. On that clock edge word_out takes the folded result and word_valid goes to 1.
- R5: A fold_count of 0 behaves exactly like a fold_count of 1.
- R6: A cycle with samp_valid low changes neither the accumulator nor the fold progress.
- R7: Once word_valid is 1, it stays 1 and word_out keeps its value until a cycle with word_ack high. In that cycle word_valid clears at the edge, unless a new word completes in the same cycle.
- R8: If a word completes while word_valid is 1 and word_ack is low, overrun becomes 1 and stays 1 until reset. The new word replaces word_out.
- R9: If a word completes in the same cycle that word_ack takes the previous word, the new word is presented with word_valid 1 and overrun is not set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| samp_a | input | 12 | Sample from converter channel A |
| samp_b | input | 12 | Sample from converter channel B |
| samp_valid | input | 1 | Both samples are valid this cycle |
| fold_count | input | 8 | Folds per output word (0 treated as 1) |
| word_out | output | 32 | Completed entropy word |
| word_valid | output | 1 | word_out holds an untaken word |
| word_ack | input | 1 | Consumer takes the current word |
| overrun | output | 1 | Sticky: a word was replaced before it was taken |

## Verification
The first directed cases are sample pairs whose high bits differ but whose low bits agree. These show whether bits above bit 4 leak into the result. An all-ones stream over seven folds gives a word of 0xFFFFFFFF, which exposes a wrong shift distance or missing truncation. A fold count of zero and of one separate the zero-as-one rule from an off-by-one count. Random streams with gaps in samp_valid, random acknowledges and fold counts that change mid-word are then compared against a reference model. They tell apart correct holding of unacknowledged words, correct overrun detection, and the case where acknowledge and completion coincide.

// File: rtl/noise_fold_pkg.sv
package noise_fold_pkg;
    localparam int SAMPLE_W = 12;
    localparam int NIB_W    = 5;
    localparam int WORD_W   = 32;
    localparam int CNT_W    = 8;

    typedef logic [NIB_W-1:0]  nib_t;
    typedef logic [WORD_W-1:0] word_t;
    typedef logic [CNT_W-1:0]  cnt_t;

    typedef struct packed {
        logic  fire;
        word_t value;
    } finished_t;

    function automatic word_t fold_step(word_t acc, nib_t nib);
        return (acc << NIB_W) ^ word_t'(nib);
    endfunction

    function automatic cnt_t eff_limit(cnt_t setting);
        return (setting == '0) ? cnt_t'(1) : setting;
    endfunction
endpackage

// File: rtl/nf_combine.sv
module nf_combine
    import noise_fold_pkg::*;
(
    input  logic [SAMPLE_W-1:0] in_a,
    input  logic [SAMPLE_W-1:0] in_b,
    output nib_t                nib
);
    logic [SAMPLE_W-1:0] mixed;
    assign mixed = in_a ^ in_b;
    assign nib   = mixed[NIB_W-1:0];
endmodule

// File: rtl/nf_fold.sv
module nf_fold
    import noise_fold_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  nib_t      nib,
    input  logic      nib_valid,
    input  cnt_t      fold_count,
    output finished_t fin
);
    word_t acc_q;
    cnt_t  cnt_q;
    word_t acc_next;
    logic  last;

    assign acc_next  = fold_step(acc_q, nib);
    assign last      = ({1'b0, cnt_q} + 1'b1) >= {1'b0, eff_limit(fold_count)};
    assign fin.fire  = nib_valid && last;
    assign fin.value = acc_next;

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q <= '0;
            cnt_q <= '0;
        end else if (nib_valid) begin
            if (last) begin
                acc_q <= '0;
                cnt_q <= '0;
            end else begin
                acc_q <= acc_next;
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    // R6
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !nib_valid |=> ($stable(acc_q) && $stable(cnt_q)));

    // R3
    restart_chk: assert property (@(posedge clk) disable iff (rst)
        fin.fire |=> (acc_q == '0 && cnt_q == '0));
endmodule

// File: rtl/nf_outstage.sv
module nf_outstage
    import noise_fold_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  finished_t fin,
    input  logic      ack,
    output word_t     word,
    output logic      valid,
    output logic      ovr
);
    always_ff @(posedge clk) begin
        if (rst) begin
            word  <= '0;
            valid <= 1'b0;
            ovr   <= 1'b0;
        end else begin
            if (fin.fire) begin
                word  <= fin.value;
                valid <= 1'b1;
                if (valid && !ack) ovr <= 1'b1;
            end else if (ack) begin
                valid <= 1'b0;
            end
        end
    end

    // R7
    hold_word_chk: assert property (@(posedge clk) disable iff (rst)
        (valid && !ack && !fin.fire) |=> (valid && $stable(word)));

    // R8
    sticky_ovr_chk: assert property (@(posedge clk) disable iff (rst)
        ovr |=> ovr);

    // R4
    present_chk: assert property (@(posedge clk) disable iff (rst)
        fin.fire |=> (valid && word == $past(fin.value)));
endmodule

// File: rtl/noise_fold_acc.sv
module noise_fold_acc
    import noise_fold_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic [SAMPLE_W-1:0] samp_a,
    input  logic [SAMPLE_W-1:0] samp_b,
    input  logic                samp_valid,
    input  logic [CNT_W-1:0]    fold_count,
    output logic [WORD_W-1:0]   word_out,
    output logic                word_valid,
    input  logic                word_ack,
    output logic                overrun
);
    nib_t      nib;
    finished_t fin;

    nf_combine u_combine (
        .in_a (samp_a),
        .in_b (samp_b),
        .nib  (nib)
    );

    nf_fold u_fold (
        .clk        (clk),
        .rst        (rst),
        .nib        (nib),
        .nib_valid  (samp_valid),
        .fold_count (fold_count),
        .fin        (fin)
    );

    nf_outstage u_out (
        .clk   (clk),
        .rst   (rst),
        .fin   (fin),
        .ack   (word_ack),
        .word  (word_out),
        .valid (word_valid),
        .ovr   (overrun)
    );

    // R9
    ack_and_fire_chk: assert property (@(posedge clk) disable iff (rst)
        (fin.fire && word_valid && word_ack && !overrun) |=> (word_valid && !overrun));
endmodule

// File: tb/noise_fold_acc_test.sv
module noise_fold_acc_test;
    logic        clk = 1'b0;
    logic        rst;
    logic [11:0] samp_a, samp_b;
    logic        samp_valid;
    logic [7:0]  fold_count;
    logic [31:0] word_out;
    logic        word_valid;
    logic        word_ack;
    logic        overrun;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    logic [31:0] m_acc, m_word;
    int          m_cnt;
    logic        m_valid, m_ovr;

    always #10 clk = ~clk;

    noise_fold_acc uut (
        .clk(clk), .rst(rst), .samp_a(samp_a), .samp_b(samp_b),
        .samp_valid(samp_valid), .fold_count(fold_count),
        .word_out(word_out), .word_valid(word_valid),
        .word_ack(word_ack), .overrun(overrun)
    );

    function automatic logic [31:0] ref_fold(logic [31:0] acc, logic [11:0] a, logic [11:0] b);
        logic [11:0] x;
        x = a ^ b;
        return {acc[26:0], 5'b0} ^ {27'b0, x[4:0]};
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        m_acc = 0; m_word = 0; m_cnt = 0; m_valid = 0; m_ovr = 0;
    endtask

    task automatic cyc(string tag, logic [11:0] a, logic [11:0] b, logic v, logic ack);
        int lim;
        logic done;
        samp_a = a; samp_b = b; samp_valid = v; word_ack = ack;
        @(posedge clk);
        lim  = (fold_count == 0) ? 1 : int'(fold_count);
        done = v && (m_cnt + 1 >= lim);
        if (done && m_valid && !ack) m_ovr = 1;
        if (done) begin
            m_word = ref_fold(m_acc, a, b);
            m_valid = 1; m_acc = 0; m_cnt = 0;
        end else begin
            if (v) begin
                m_acc = ref_fold(m_acc, a, b);
                m_cnt++;
            end
            if (ack) m_valid = 0;
        end
        @(negedge clk);
        check({tag, " word_valid"}, {31'b0, word_valid}, {31'b0, m_valid});
        check({tag, " overrun"}, {31'b0, overrun}, {31'b0, m_ovr});
        if (m_valid) check({tag, " word_out"}, word_out, m_word);
    endtask

    task automatic do_reset();
        rst = 1; samp_valid = 0; word_ack = 0; samp_a = 0; samp_b = 0;
        @(posedge clk); @(posedge clk);
        @(negedge clk);
        rst = 0;
        model_reset();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        fold_count = 8'd32;
        do_reset();
        // R1 reset state
        check("R1 word_valid", {31'b0, word_valid}, 32'd0);
        check("R1 overrun", {31'b0, overrun}, 32'd0);
        check("R1 word_out", word_out, 32'd0);

        // R2: high bits differ, low bits equal -> folded value 0; fold_count 1
        fold_count = 8'd1;
        cyc("R2", 12'hFE5, 12'h005, 1'b1, 1'b0);
        check("R2 high bits ignored", word_out, 32'h0);
        cyc("R2", 12'hA13, 12'h5E6, 1'b1, 1'b1);
        check("R2 xor low bits", word_out, 32'h15);

        // R3: seven all-ones folds fill and truncate
        do_reset();
        fold_count = 8'd7;
        for (int i = 0; i < 7; i++) cyc("R3", 12'h01F, 12'h000, 1'b1, 1'b0);
        check("R3 all ones", word_out, 32'hFFFFFFFF);
        // R3 restart from zero: next word of single ones, fold 2 -> 0x21
        fold_count = 8'd2;
        cyc("R3", 12'h001, 12'h000, 1'b1, 1'b1);
        cyc("R3", 12'h001, 12'h000, 1'b1, 1'b0);
        check("R3 restart", word_out, 32'h21);

        // R5: fold_count 0 acts as 1
        do_reset();
        fold_count = 8'd0;
        cyc("R5", 12'h007, 12'h000, 1'b1, 1'b0);
        check("R5 one fold", {31'b0, word_valid}, 32'd1);
        check("R5 value", word_out, 32'h7);

        // R6: idle cycles have no effect on the word under construction
        do_reset();
        fold_count = 8'd3;
        cyc("R6", 12'h003, 12'h000, 1'b1, 1'b0);
        for (int i = 0; i < 5; i++) cyc("R6", 12'hFFF, 12'h000, 1'b0, 1'b0);
        cyc("R6", 12'h002, 12'h000, 1'b1, 1'b0);
        cyc("R6", 12'h001, 12'h000, 1'b1, 1'b0);
        check("R6 idle ignored", word_out, 32'h0C41);

        // R7: word held until ack
        for (int i = 0; i < 4; i++) cyc("R7", 12'h0, 12'h0, 1'b0, 1'b0);
        check("R7 held", word_out, 32'h0C41);
        cyc("R7", 12'h0, 12'h0, 1'b0, 1'b1);
        check("R7 cleared", {31'b0, word_valid}, 32'd0);

        // R9: ack coincides with completion
        do_reset();
        fold_count = 8'd1;
        cyc("R9", 12'h004, 12'h0, 1'b1, 1'b0);
        cyc("R9", 12'h009, 12'h0, 1'b1, 1'b1);
        check("R9 no overrun", {31'b0, overrun}, 32'd0);
        check("R9 new word", word_out, 32'h9);

        // R8: completion without ack
        cyc("R8", 12'h00A, 12'h0, 1'b1, 1'b0);
        check("R8 overrun set", {31'b0, overrun}, 32'd1);
        check("R8 replaced", word_out, 32'hA);
        cyc("R8", 12'h0, 12'h0, 1'b0, 1'b1);
        check("R8 sticky", {31'b0, overrun}, 32'd1);

        // Random phase: R4 R7 R8 R9 against model
        do_reset();
        for (int i = 0; i < 6000; i++) begin
            if (i % 500 == 0) begin
                int r;
                r = int'($urandom_range(0, 9));
                fold_count = (r == 0) ? 8'd0 : 8'($urandom_range(1, 40));
            end
            if (i % 1500 == 0 && i > 0) do_reset();
            cyc("R4/R7/R8/R9 random",
                12'($urandom), 12'($urandom),
                ($urandom_range(0, 9) < 6), ($urandom_range(0, 9) < 3));
        end

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end
endmodule